// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation descriptors out of memory, one level at a time. A walk starts from a 64-bit root pointer: bits [63:32] hold the attribute word and bits [31:0] hold the table base word. The root selects a first-level table of 8-byte long descriptors. An entry there either ends the walk as a large page, or points to a second-level table of 4-byte short table descriptors. Those in turn point to third-level tables of 4-byte short page descriptors.

While it walks, the block keeps the status bits of each descriptor up to date in memory. It sets the used flag of every descriptor it accepts. After a successful write access it also sets the modified flag of the final page descriptor. All memory traffic goes through a single 32-bit port that carries one request at a time.

A caller pulses start with an address and a direction. It then waits for the one-cycle done pulse, which carries the physical address, a fault flag, a 2-bit cause and the level at which the walk stopped. Limit fields, access levels, supervisor and shared flags are stored in the descriptors but are not enforced.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and fault_o are all low.
- R2: Entry addresses are computed as follows. A table base is word[31:4] followed by four zero bits. The VA index fields are A = VA[31:25], B = VA[24:18] and C = VA[17:13]. The first-level entry sits at base + 8*A and is read as two words: the attribute word at that address, then the base word at +4. The second- and third-level entries sit at base + 4*B and base + 4*C.
- R3: A walk that ends at a third-level page descriptor (type 1) returns the physical address word[31:13] followed by VA[12:0].
- R4: A first-level entry with type 1 ends the walk after two reads. The physical address is its base word [31:25] followed by VA[24:0].
- R5: The type field is bits [1:0]. A type 0 descriptor ends the walk with fault cause 1 (invalid). level_o reports where the walk stopped: 0 for the root, 1, 2 or 3 for the table levels. A successful walk reports cause 0.
- R6: Each level accepts only certain types. The root must be type 3. The first level accepts type 1 or 2, the second level type 2 and the third level type 1. Any other nonzero type ends the walk with cause 3 (bad type).
- R7: On a write access, a descriptor with write-protect (bit 2) set ends the walk with cause 2. On a read access, write-protect has no effect.
- R8: Each accepted descriptor whose used flag (bit 3) is clear is written back once with bit 3 set. A descriptor that already has bit 3 set is not written.
- R9: A successful write access whose final page descriptor has the modified flag (bit 4) clear causes one further write of that descriptor with bit 4 set.
- R10: On a fault, pa_o is zero and fault_o is high, and the faulting descriptor is not written.
- R11: done_o is high for exactly one cycle per walk. pa_o, fault_o, cause_o and level_o hold their values until the next done.
- R12: A start pulse is ignored while busy_o is high, including during the done cycle.
- R13: Once mem_req_o rises, the request and its address, direction and write data stay stable until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (used only when idle) |
| va_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | 1 for a write access, 0 for a read |
| root_ptr_i | input | 64 | Root pointer: [63:32] attribute word, [31:0] base word |
| busy_o | output | 1 | Walk in progress or completing |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address (zero on fault) |
| fault_o | output | 1 | Walk ended in a fault |
| cause_o | output | 2 | 0 none, 1 invalid, 2 write-protect, 3 bad type |
| level_o | output | 2 | Level at which the walk stopped |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted (read data valid) |
| mem_rdata_i | input | 32 | Read data |

## Verification
Two functions can meet in one cycle. The first is the completion of one walk, the done pulse. The second is a new start request arriving at the same time. The bench raises start_i exactly in the cycle where done_o is observed high. It then requires that the following cycle shows the walker idle with no memory request and no extra reads. A second case drives a start with a different address and direction in the middle of a walk. The bench then checks that only one done arrives and that it carries the first walk's translation and read count.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    DT_INV   = 2'd0,
    DT_PAGE  = 2'd1,
    DT_SHORT = 2'd2,
    DT_LONG  = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_INV   = 2'd1,
    CAUSE_WPROT = 2'd2,
    CAUSE_TYPE  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LA,
    ST_RD_LB,
    ST_RD_S,
    ST_EVAL,
    ST_WR_U,
    ST_WR_M,
    ST_DONE
  } state_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BIT_WP  = 2;
  localparam int unsigned BIT_USE = 3;
  localparam int unsigned BIT_MOD = 4;
endpackage

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
  import ptw_pkg::*;
(
  input  logic [4:0] attr_i,
  input  logic [1:0] lvl_i,
  input  logic       write_i,
  output logic       fault_o,
  output cause_e     cause_o,
  output logic       is_page_o,
  output logic       need_used_o,
  output logic       need_mod_o
);
  dtype_e dt;
  logic   type_ok;

  always_comb begin
    dt = dtype_e'(attr_i[1:0]);
    unique case (lvl_i)
      2'd0:    type_ok = (dt == DT_LONG);
      2'd1:    type_ok = (dt == DT_PAGE) || (dt == DT_SHORT);
      2'd2:    type_ok = (dt == DT_SHORT);
      default: type_ok = (dt == DT_PAGE);
    endcase
    fault_o = 1'b1;
    cause_o = CAUSE_NONE;
    if (dt == DT_INV)                                     cause_o = CAUSE_INV;
    else if (!type_ok)                                    cause_o = CAUSE_TYPE;
    else if (write_i && attr_i[BIT_WP] && lvl_i != 2'd0)  cause_o = CAUSE_WPROT;
    else                                                  fault_o = 1'b0;
    is_page_o   = (dt == DT_PAGE);
    // root pointer is a register: never written back
    need_used_o = !fault_o && !attr_i[BIT_USE] && (lvl_i != 2'd0);
    need_mod_o  = !fault_o && is_page_o && write_i && !attr_i[BIT_MOD];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned A_W   = 7,
  parameter int unsigned B_W   = 7,
  parameter int unsigned C_W   = 5,
  parameter int unsigned OFF_W = 13
) (
  input  logic [31:0] base_i,
  input  logic [31:0] va_i,
  input  logic [1:0]  lvl_i,
  output logic [31:0] entry_o,
  output logic [31:0] pa_big_o,
  output logic [31:0] pa_small_o
);
  localparam int unsigned C_LSB = OFF_W;
  localparam int unsigned B_LSB = C_LSB + C_W;
  localparam int unsigned A_LSB = B_LSB + B_W;
  localparam int unsigned VA_W  = A_LSB + A_W;

  logic [31:0] tbl, off;

  always_comb begin
    tbl = base_i & ~32'hF;
    unique case (lvl_i)
      2'd1:    off = 32'(va_i[A_LSB +: A_W]) << 3;
      2'd2:    off = 32'(va_i[B_LSB +: B_W]) << 2;
      default: off = 32'(va_i[C_LSB +: C_W]) << 2;
    endcase
    entry_o    = tbl + off;
    pa_big_o   = {base_i[31:A_LSB], va_i[A_LSB-1:0]};
    pa_small_o = {base_i[31:OFF_W], va_i[OFF_W-1:0]};
  end

  initial begin
    if (VA_W != 32) $error("index split must cover 32 VA bits");
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned A_W   = 7,
  parameter int unsigned B_W   = 7,
  parameter int unsigned C_W   = 5,
  parameter int unsigned OFF_W = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] va_i,
  input  logic        write_i,
  input  logic [63:0] root_ptr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] pa_o,
  output logic        fault_o,
  output logic [1:0]  cause_o,
  output logic [1:0]  level_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);
  state_e      state_q;
  logic [31:0] va_q, desc_q, base_q, cur_q, pa_q;
  logic        wr_q, fault_q;
  logic [1:0]  lvl_q, flvl_q;
  cause_e      cause_q;

  logic        idle;
  logic [4:0]  chk_attr;
  logic [1:0]  chk_lvl, gen_lvl;
  logic [31:0] gen_base, gen_va, entry, pa_big, pa_small;
  logic        chk_fault, chk_page, chk_used, chk_mod, chk_wr;
  cause_e      chk_cause;

  assign idle     = (state_q == ST_IDLE);
  assign chk_attr = idle ? root_ptr_i[36:32] : desc_q[4:0];
  assign chk_lvl  = idle ? 2'd0 : lvl_q;
  assign chk_wr   = idle ? write_i : wr_q;
  assign gen_base = idle ? root_ptr_i[31:0] : base_q;
  assign gen_va   = idle ? va_i : va_q;
  assign gen_lvl  = idle ? 2'd1 : lvl_q + 2'd1;

  ptw_desc_check u_chk (
    .attr_i      (chk_attr),
    .lvl_i       (chk_lvl),
    .write_i     (chk_wr),
    .fault_o     (chk_fault),
    .cause_o     (chk_cause),
    .is_page_o   (chk_page),
    .need_used_o (chk_used),
    .need_mod_o  (chk_mod)
  );

  ptw_addr_gen #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .OFF_W(OFF_W)) u_gen (
    .base_i     (gen_base),
    .va_i       (gen_va),
    .lvl_i      (gen_lvl),
    .entry_o    (entry),
    .pa_big_o   (pa_big),
    .pa_small_o (pa_small)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      lvl_q   <= '0;
      desc_q  <= '0;
      base_q  <= '0;
      cur_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      flvl_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q <= va_i;
          wr_q <= write_i;
          if (chk_fault) begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            cause_q <= chk_cause;
            flvl_q  <= 2'd0;
            state_q <= ST_DONE;
          end else begin
            cur_q   <= entry;
            lvl_q   <= 2'd1;
            state_q <= ST_RD_LA;
          end
        end
        ST_RD_LA: if (mem_ack_i) begin
          desc_q  <= mem_rdata_i;
          state_q <= ST_RD_LB;
        end
        ST_RD_LB: if (mem_ack_i) begin
          base_q  <= mem_rdata_i;
          state_q <= ST_EVAL;
        end
        ST_RD_S: if (mem_ack_i) begin
          desc_q  <= mem_rdata_i;
          base_q  <= mem_rdata_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (chk_fault) begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            cause_q <= chk_cause;
            flvl_q  <= lvl_q;
            state_q <= ST_DONE;
          end else if (chk_used) begin
            state_q <= ST_WR_U;
          end else if (chk_mod) begin
            state_q <= ST_WR_M;
          end else if (chk_page) begin
            pa_q    <= (lvl_q == 2'd1) ? pa_big : pa_small;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            flvl_q  <= lvl_q;
            state_q <= ST_DONE;
          end else begin
            cur_q   <= entry;
            lvl_q   <= lvl_q + 2'd1;
            state_q <= ST_RD_S;
          end
        end
        // re-evaluate after each status write so the next step sees updated bits
        ST_WR_U: if (mem_ack_i) begin
          desc_q[BIT_USE] <= 1'b1;
          state_q         <= ST_EVAL;
        end
        ST_WR_M: if (mem_ack_i) begin
          desc_q[BIT_MOD] <= 1'b1;
          state_q         <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_RD_LA) || (state_q == ST_RD_LB) || (state_q == ST_RD_S) ||
                  (state_q == ST_WR_U)  || (state_q == ST_WR_M);
    mem_we_o    = (state_q == ST_WR_U) || (state_q == ST_WR_M);
    mem_addr_o  = cur_q + ((state_q == ST_RD_LB) ? 32'd4 : 32'd0);
    mem_wdata_o = '0;
    if (state_q == ST_WR_U) mem_wdata_o = desc_q | (32'd1 << BIT_USE);
    if (state_q == ST_WR_M) mem_wdata_o = desc_q | (32'd1 << BIT_MOD);
  end

  assign busy_o  = !idle;
  assign done_o  = (state_q == ST_DONE);
  assign pa_o    = pa_q;
  assign fault_o = fault_q;
  assign cause_o = cause_q;
  assign level_o = flvl_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);
  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> done_o || ($stable(pa_o) && $stable(fault_o) && $stable(cause_o)));
  a_r10_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> pa_o == 32'd0 && cause_o != 2'd0);
  a_r5_ok_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> cause_o == 2'd0);
  a_r8_wb_used_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_USE]);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VA    = 32'h0208_6123;
  localparam logic [31:0] PA_C  = 32'h00AB_C123;
  localparam logic [31:0] PA_A  = 32'h5E08_6123;
  localparam int IA = 2, IAB = 3, IB = 258, IC = 387;

  typedef struct packed {
    logic [31:0] a_attr;
    logic [31:0] a_base;
    logic [31:0] b;
    logic [31:0] c;
    logic        wr;
    logic        fault;
    logic [1:0]  cause;
    logic [1:0]  lvl;
    logic [31:0] pa;
    logic [2:0]  nwr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'hA, 32'h400, 32'h60A, 32'hABC009, 1'b0, 1'b0, 2'd0, 2'd3, PA_C, 3'd0, 4'd3},  // R3
    '{32'h2, 32'h400, 32'h602, 32'hABC001, 1'b0, 1'b0, 2'd0, 2'd3, PA_C, 3'd3, 4'd8},  // R8
    '{32'hA, 32'h400, 32'h60A, 32'hABC009, 1'b1, 1'b0, 2'd0, 2'd3, PA_C, 3'd1, 4'd9},  // R9
    '{32'h2, 32'h400, 32'h602, 32'hABC001, 1'b1, 1'b0, 2'd0, 2'd3, PA_C, 3'd4, 4'd9},
    '{32'hA, 32'h400, 32'h60A, 32'hABC019, 1'b1, 1'b0, 2'd0, 2'd3, PA_C, 3'd0, 4'd9},
    '{32'h0, 32'h400, 32'h60A, 32'hABC009, 1'b0, 1'b1, 2'd1, 2'd1, 32'd0, 3'd0, 4'd5}, // R5
    '{32'hA, 32'h400, 32'h000, 32'hABC009, 1'b0, 1'b1, 2'd1, 2'd2, 32'd0, 3'd0, 4'd5},
    '{32'hA, 32'h400, 32'h60A, 32'h000000, 1'b0, 1'b1, 2'd1, 2'd3, 32'd0, 3'd0, 4'd5},
    '{32'hA, 32'h400, 32'h60E, 32'hABC009, 1'b1, 1'b1, 2'd2, 2'd2, 32'd0, 3'd0, 4'd7}, // R7
    '{32'hA, 32'h400, 32'h60A, 32'hABC00D, 1'b0, 1'b0, 2'd0, 2'd3, PA_C, 3'd0, 4'd7},
    '{32'h9, 32'h5E000000, 32'h60A, 32'hABC009, 1'b0, 1'b0, 2'd0, 2'd1, PA_A, 3'd0, 4'd4}, // R4
    '{32'h1, 32'h5E000000, 32'h60A, 32'hABC009, 1'b1, 1'b0, 2'd0, 2'd1, PA_A, 3'd2, 4'd9},
    '{32'hA, 32'h400, 32'h60B, 32'hABC009, 1'b0, 1'b1, 2'd3, 2'd2, 32'd0, 3'd0, 4'd6}, // R6
    '{32'hA, 32'h400, 32'h60A, 32'hABC00A, 1'b0, 1'b1, 2'd3, 2'd3, 32'd0, 3'd0, 4'd6},
    '{32'hB, 32'h400, 32'h60A, 32'hABC009, 1'b0, 1'b1, 2'd3, 2'd1, 32'd0, 3'd0, 4'd6},
    '{32'h2, 32'h400, 32'h602, 32'h000000, 1'b0, 1'b1, 2'd1, 2'd3, 32'd0, 3'd2, 4'd10}, // R10
    '{32'hA, 32'h400, 32'h60A, 32'hABC005, 1'b1, 1'b1, 2'd2, 2'd3, 32'd0, 3'd0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va_s = '0;
  logic        wr_s = 1'b0;
  logic [63:0] root_s = {32'h3, 32'h0};
  logic        busy, done, fault, mem_req, mem_we, mem_ack;
  logic [31:0] pa, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  cause, level;

  logic [31:0] mem [0:511];
  logic [31:0] log_addr [0:63];
  int          wr_cnt = 0, rd_cnt = 0;
  int          checks = 0, errs = 0;
  logic        finished = 1'b0;

  logic        got;
  logic [31:0] r_pa;
  logic        r_fault;
  logic [1:0]  r_cause, r_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va_s), .write_i(wr_s),
    .root_ptr_i(root_s), .busy_o(busy), .done_o(done), .pa_o(pa), .fault_o(fault),
    .cause_o(cause), .level_o(level), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[10:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[10:2]];
        log_addr[rd_cnt % 64] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] a_attr, input logic [31:0] a_base,
                       input logic [31:0] b, input logic [31:0] c);
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem[IA] = a_attr; mem[IAB] = a_base; mem[IB] = b; mem[IC] = c;
  endtask

  task automatic wait_done();
    got = 1'b0;
    for (int i = 0; i < 400 && !got; i++) begin
      if (done) begin
        got = 1'b1; r_pa = pa; r_fault = fault; r_cause = cause; r_lvl = level;
      end else @(negedge clk);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr);
    @(negedge clk);
    start = 1'b1; va_s = va; wr_s = wr;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL R11 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    int w0, r0;
    logic [31:0] hold_pa;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !fault, 1, "reset outputs", {busy, done, mem_req, fault}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].a_attr, VECS[v].a_base, VECS[v].b, VECS[v].c);
      w0 = wr_cnt;
      walk(VA, VECS[v].wr);
      chk(got, 11, $sformatf("vec%0d done", v), 32'(got), 1);
      chk(r_fault == VECS[v].fault, VECS[v].req, $sformatf("vec%0d fault", v), 32'(r_fault), 32'(VECS[v].fault));
      chk(r_cause == VECS[v].cause, VECS[v].req, $sformatf("vec%0d cause", v), 32'(r_cause), 32'(VECS[v].cause));
      chk(r_lvl == VECS[v].lvl, 5, $sformatf("vec%0d level", v), 32'(r_lvl), 32'(VECS[v].lvl));
      chk(r_pa == VECS[v].pa, VECS[v].req, $sformatf("vec%0d pa", v), r_pa, VECS[v].pa);
      chk(wr_cnt - w0 == int'(VECS[v].nwr), VECS[v].req, $sformatf("vec%0d writes", v), 32'(wr_cnt - w0), 32'(VECS[v].nwr));
    end

    // R8 R9 memory contents after full write walk with all status bits clear
    setup(32'h2, 32'h400, 32'h602, 32'hABC001);
    walk(VA, 1'b1);
    chk(mem[IA] == 32'hA, 8, "A used set", mem[IA], 32'hA);
    chk(mem[IB] == 32'h60A, 8, "B used set", mem[IB], 32'h60A);
    chk(mem[IC] == 32'hABC019, 9, "C used+mod set", mem[IC], 32'hABC019);

    // R10 faulting descriptor left untouched
    setup(32'hA, 32'h400, 32'h60A, 32'hABC005);
    walk(VA, 1'b1);
    chk(mem[IC] == 32'hABC005, 10, "fault desc unchanged", mem[IC], 32'hABC005);

    // R2 read address order
    setup(32'hA, 32'h400, 32'h60A, 32'hABC009);
    r0 = rd_cnt;
    walk(VA, 1'b0);
    chk(rd_cnt - r0 == 4, 2, "read count", 32'(rd_cnt - r0), 4);
    chk(log_addr[r0 % 64] == 32'h8, 2, "A attr addr", log_addr[r0 % 64], 32'h8);
    chk(log_addr[(r0 + 1) % 64] == 32'hC, 2, "A base addr", log_addr[(r0 + 1) % 64], 32'hC);
    chk(log_addr[(r0 + 2) % 64] == 32'h408, 2, "B addr", log_addr[(r0 + 2) % 64], 32'h408);
    chk(log_addr[(r0 + 3) % 64] == 32'h60C, 2, "C addr", log_addr[(r0 + 3) % 64], 32'h60C);

    // R11 result held after done
    hold_pa = pa;
    repeat (4) @(negedge clk);
    chk(pa == hold_pa && !done, 11, "result held", pa, hold_pa);

    // R4 large page: two reads only
    setup(32'h9, 32'h5E000000, 32'h60A, 32'hABC009);
    r0 = rd_cnt;
    walk(VA, 1'b0);
    chk(rd_cnt - r0 == 2, 4, "A page reads", 32'(rd_cnt - r0), 2);

    // R5 R6 root pointer faults, no memory traffic
    root_s = {32'h0, 32'h0};
    r0 = rd_cnt;
    walk(VA, 1'b0);
    chk(r_fault && r_cause == 2'd1 && r_lvl == 2'd0, 5, "root invalid", {r_fault, r_cause, r_lvl}, 32'h14);
    root_s = {32'h2, 32'h0};
    walk(VA, 1'b0);
    chk(r_fault && r_cause == 2'd3 && r_lvl == 2'd0, 6, "root bad type", {r_fault, r_cause, r_lvl}, 32'h1C);
    chk(rd_cnt == r0, 6, "root fault reads", 32'(rd_cnt - r0), 0);
    root_s = {32'h3, 32'h0};

    // R12 start in mid-walk ignored
    setup(32'hA, 32'h400, 32'h60A, 32'hABC009);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk); start = 1'b1; va_s = VA; wr_s = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; va_s = 32'h0; wr_s = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(r_pa == PA_C && !r_fault, 12, "mid-walk start pa", r_pa, PA_C);
    chk(rd_cnt - r0 == 4 && wr_cnt == w0, 12, "mid-walk start traffic", 32'(rd_cnt - r0), 4);
    // R12 start coincident with done
    start = 1'b1; va_s = VA; wr_s = 1'b1;
    r0 = rd_cnt;
    @(negedge clk); start = 1'b0;
    chk(!busy && !mem_req, 12, "start at done ignored", {busy, mem_req}, 0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == r0 && !busy, 12, "no walk after done start", 32'(rd_cnt - r0), 0);

    // R13 checked by property a_r13_req_hold across all walks above
    summary();
  end
endmodule